// File: doc/BRIEF.md
# Polled EEPROM Word Access Engine

This block gives a host a small register window through which it reads or programs a single 16-bit word of a serial EEPROM. The host writes one command word that carries the go bit, the word address and (for programming) the data. It then polls that same register until its done bit reads 1. The engine runs the whole serial exchange itself. For a read it sends one frame and captures the word. For a program it sends a write-enable frame and a program frame, then polls the device status until the write cycle has finished.

A separate control register carries a commit handshake. Setting the request bit raises an output toward the agent that copies the working contents into non-volatile storage. When that agent acknowledges, the request drops and a completion flag is set. The same register shows whether a serial command is still in flight.

Top module: `eeword_engine`

## Requirements
- R1: Registers sit at offset 0 (read command), offset 1 (program command) and offset 2 (control); offset 3 reads zero. After reset every register reads 0x00000000, spi_cs_n is high and upd_req is low.
- R2: In the read command register, bit 0 is the go bit, bit 1 is done, bits 15:2 hold the word address and bits 31:16 hold the returned word. A read sends opcode 0x03 and then the 16-bit byte address, which is twice the word address. It then clocks in 16 bits. The byte at the even address becomes bits 7:0 of the word and the byte at the odd address becomes bits 15:8.
- R3: In the program command register, bit 0 is the go bit, bit 1 is done, bits 15:2 hold the word address and bits 31:16 hold the data. A program sends a write-enable frame (0x06). It then sends a frame made of opcode 0x02, the byte address (twice the word address), the low data byte and then the high data byte.
- R4: After the program frame, the engine repeats status frames (0x05, then 8 bits in). Bit 0 of the received status byte is the write-in-progress flag. Program done is set only after a status byte shows that flag at 0.
- R5: An accepted command clears the done bit of its own register. Done, the address, the data and any returned word then stay unchanged until the next accepted command to that register.
- R6: Bit 31 of the control register reads 1 while a serial command is in flight. A command written while it is 1 has no effect on either command register or on the EEPROM.
- R7: A write to a command register with bit 0 at 0 starts nothing and changes nothing in that register.
- R8: Writing 1 to control bit 23 while no commit is pending raises upd_req and control bit 23, and clears control bit 26. While the request is pending, a cycle with upd_ack high clears the request and sets bit 26. Writing 0 to bit 23 changes nothing.
- R9: The serial port runs in mode 0: sclk idles low, data are shifted out MSB first on the falling edge and sampled on the rising edge, and sclk stays low whenever spi_cs_n is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| upd_req | output | 1 | Commit request toward the storage agent |
| upd_ack | input | 1 | Commit finished acknowledge |
| spi_sclk | output | 1 | Serial clock |
| spi_cs_n | output | 1 | Serial chip select, active low |
| spi_mosi | output | 1 | Serial data to the EEPROM |
| spi_miso | input | 1 | Serial data from the EEPROM |

## Verification
The embedded properties check several rules on every cycle. Serial clock stays low while the chip is deselected. Program done rises only on a status frame that reports the device idle. A command arriving while the engine is busy leaves the latched address untouched. An accepted command drops done on the next cycle. An acknowledged commit sets its flag. Only the bench's scenarios, driven against an EEPROM model, can show the rest: the frame contents and opcode order, the byte order inside a word, the doubling of the address, the count of status polls before completion, and that an ignored command leaves the stored bytes unchanged.

// File: rtl/eew_pkg.sv
`timescale 1ns/1ps
package eew_pkg;
  localparam int FRAME_W = 40;
  localparam int RX_W    = 16;

  localparam logic [1:0] OFF_RD  = 2'd0;
  localparam logic [1:0] OFF_WR  = 2'd1;
  localparam logic [1:0] OFF_CTL = 2'd2;

  localparam int BIT_GO       = 0;
  localparam int BIT_DONE     = 1;
  localparam int BIT_ADDR     = 2;
  localparam int BIT_DATA     = 16;
  localparam int BIT_UPD_REQ  = 23;
  localparam int BIT_UPD_DONE = 26;
  localparam int BIT_BUSY     = 31;

  localparam logic [7:0] OP_READ = 8'h03;
  localparam logic [7:0] OP_WREN = 8'h06;
  localparam logic [7:0] OP_PROG = 8'h02;
  localparam logic [7:0] OP_STAT = 8'h05;

  typedef enum logic [2:0] {
    SQ_IDLE, SQ_READ, SQ_WREN, SQ_PROG, SQ_POLL
  } seq_state_t;
endpackage

// File: rtl/eew_spi_shifter.sv
`timescale 1ns/1ps
module eew_spi_shifter #(
  parameter int HALF_DIV = 2,
  parameter int FRAME_W  = 40,
  parameter int RX_W     = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start_i,
  input  logic [5:0]         len_i,
  input  logic [FRAME_W-1:0] tx_i,
  output logic               done_o,
  output logic [RX_W-1:0]    rx_o,
  output logic               sclk_o,
  output logic               cs_n_o,
  output logic               mosi_o,
  input  logic               miso_i
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(HALF_DIV - 1);

  logic               active_q, active_n;
  logic               sclk_q, sclk_n;
  logic               done_q, done_n;
  logic [DW-1:0]      div_q, div_n;
  logic [5:0]         cnt_q, cnt_n;
  logic [5:0]         len_q, len_n;
  logic [FRAME_W-1:0] tx_q, tx_n;
  logic [RX_W-1:0]    rx_q, rx_n;

  always_comb begin
    active_n = active_q;
    sclk_n   = sclk_q;
    done_n   = 1'b0;
    div_n    = div_q;
    cnt_n    = cnt_q;
    len_n    = len_q;
    tx_n     = tx_q;
    rx_n     = rx_q;
    if (!active_q) begin
      if (start_i) begin
        active_n = 1'b1;
        sclk_n   = 1'b0;
        div_n    = '0;
        cnt_n    = '0;
        len_n    = len_i;
        tx_n     = tx_i;
      end
    end else if (div_q == DIV_LAST) begin
      div_n = '0;
      if (!sclk_q) begin
        sclk_n = 1'b1;
        rx_n   = {rx_q[RX_W-2:0], miso_i};
      end else begin
        sclk_n = 1'b0;
        tx_n   = {tx_q[FRAME_W-2:0], 1'b0};
        cnt_n  = cnt_q + 6'd1;
        if (cnt_q + 6'd1 == len_q) begin
          active_n = 1'b0;
          done_n   = 1'b1;
        end
      end
    end else begin
      div_n = div_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      sclk_q   <= 1'b0;
      done_q   <= 1'b0;
      div_q    <= '0;
      cnt_q    <= '0;
      len_q    <= '0;
      tx_q     <= '0;
      rx_q     <= '0;
    end else begin
      active_q <= active_n;
      sclk_q   <= sclk_n;
      done_q   <= done_n;
      div_q    <= div_n;
      cnt_q    <= cnt_n;
      len_q    <= len_n;
      tx_q     <= tx_n;
      rx_q     <= rx_n;
    end
  end

  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign cs_n_o = !active_q;
  assign mosi_o = active_q & tx_q[FRAME_W-1];

  // R9: no clock activity while deselected
  a_r9_sclk_low_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n_o |-> !sclk_o);
endmodule

// File: rtl/eew_seq.sv
`timescale 1ns/1ps
module eew_seq
  import eew_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               rd_go_i,
  input  logic               wr_go_i,
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [15:0]        data_i,
  output logic               busy_o,
  output logic               rd_fin_o,
  output logic               wr_fin_o,
  output logic [15:0]        rd_word_o,
  output logic               xfer_start_o,
  output logic [5:0]         xfer_len_o,
  output logic [FRAME_W-1:0] xfer_tx_o,
  input  logic               xfer_done_i,
  input  logic [RX_W-1:0]    xfer_rx_i
);
  seq_state_t        state_q, state_n;
  logic              wait_q, wait_n;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [15:0]       data_q, data_n;
  logic [15:0]       byte_addr;

  assign byte_addr = {{(15-ADDR_W){1'b0}}, addr_q, 1'b0};

  always_comb begin
    state_n      = state_q;
    wait_n       = wait_q;
    addr_n       = addr_q;
    data_n       = data_q;
    rd_fin_o     = 1'b0;
    wr_fin_o     = 1'b0;
    xfer_start_o = 1'b0;
    unique case (state_q)
      SQ_IDLE: begin
        if (rd_go_i) begin
          state_n = SQ_READ;
          addr_n  = addr_i;
        end else if (wr_go_i) begin
          state_n = SQ_WREN;
          addr_n  = addr_i;
          data_n  = data_i;
        end
      end
      default: begin
        if (!wait_q) begin
          xfer_start_o = 1'b1;
          wait_n       = 1'b1;
        end else if (xfer_done_i) begin
          wait_n = 1'b0;
          unique case (state_q)
            SQ_READ: begin
              state_n  = SQ_IDLE;
              rd_fin_o = 1'b1;
            end
            SQ_WREN: state_n = SQ_PROG;
            SQ_PROG: state_n = SQ_POLL;
            default: begin
              if (!xfer_rx_i[0]) begin
                state_n  = SQ_IDLE;
                wr_fin_o = 1'b1;
              end
            end
          endcase
        end
      end
    endcase
  end

  always_comb begin
    xfer_tx_o  = '0;
    xfer_len_o = 6'd8;
    unique case (state_q)
      SQ_READ: begin
        xfer_tx_o  = {OP_READ, byte_addr, 16'h0000};
        xfer_len_o = 6'd40;
      end
      SQ_WREN: xfer_tx_o = {OP_WREN, 32'h0};
      SQ_PROG: begin
        xfer_tx_o  = {OP_PROG, byte_addr, data_q[7:0], data_q[15:8]};
        xfer_len_o = 6'd40;
      end
      SQ_POLL: begin
        xfer_tx_o  = {OP_STAT, 32'h0};
        xfer_len_o = 6'd16;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= SQ_IDLE;
      wait_q  <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      state_q <= state_n;
      wait_q  <= wait_n;
      addr_q  <= addr_n;
      data_q  <= data_n;
    end
  end

  assign busy_o    = (state_q != SQ_IDLE);
  assign rd_word_o = {xfer_rx_i[7:0], xfer_rx_i[15:8]};

  // R4: completion of a program only on a status frame reporting idle
  a_r4_done_needs_idle_status: assert property (@(posedge clk) disable iff (!rst_n)
    wr_fin_o |-> (state_q == SQ_POLL) && xfer_done_i && !xfer_rx_i[0]);
endmodule

// File: rtl/eew_regs.sv
`timescale 1ns/1ps
module eew_regs
  import eew_pkg::*;
#(
  parameter int ADDR_W = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic              busy_i,
  input  logic              rd_fin_i,
  input  logic              wr_fin_i,
  input  logic [15:0]       rd_word_i,
  output logic              rd_go_o,
  output logic              wr_go_o,
  output logic [ADDR_W-1:0] cmd_addr_o,
  output logic [15:0]       cmd_data_o,
  output logic              upd_req_o,
  input  logic              upd_ack_i
);
  logic              rd_done_q, rd_done_n, wr_done_q, wr_done_n;
  logic [ADDR_W-1:0] rd_addr_q, rd_addr_n, wr_addr_q, wr_addr_n;
  logic [15:0]       rd_data_q, rd_data_n, wr_data_q, wr_data_n;
  logic              upd_req_q, upd_req_n, upd_done_q, upd_done_n;
  logic              ctl_req_wr;
  logic              unused_wdata;

  assign rd_go_o    = reg_wr_i && (reg_addr_i == OFF_RD) && reg_wdata_i[BIT_GO] && !busy_i;
  assign wr_go_o    = reg_wr_i && (reg_addr_i == OFF_WR) && reg_wdata_i[BIT_GO] && !busy_i;
  assign cmd_addr_o = reg_wdata_i[BIT_ADDR +: ADDR_W];
  assign cmd_data_o = reg_wdata_i[BIT_DATA +: 16];
  assign ctl_req_wr = reg_wr_i && (reg_addr_i == OFF_CTL) && reg_wdata_i[BIT_UPD_REQ];
  assign unused_wdata = ^reg_wdata_i;

  always_comb begin
    rd_done_n  = rd_done_q;
    rd_addr_n  = rd_addr_q;
    rd_data_n  = rd_data_q;
    wr_done_n  = wr_done_q;
    wr_addr_n  = wr_addr_q;
    wr_data_n  = wr_data_q;
    upd_req_n  = upd_req_q;
    upd_done_n = upd_done_q;
    if (rd_go_o) begin
      rd_done_n = 1'b0;
      rd_addr_n = cmd_addr_o;
    end else if (rd_fin_i) begin
      rd_done_n = 1'b1;
      rd_data_n = rd_word_i;
    end
    if (wr_go_o) begin
      wr_done_n = 1'b0;
      wr_addr_n = cmd_addr_o;
      wr_data_n = cmd_data_o;
    end else if (wr_fin_i) begin
      wr_done_n = 1'b1;
    end
    if (ctl_req_wr && !upd_req_q) begin
      upd_req_n  = 1'b1;
      upd_done_n = 1'b0;
    end else if (upd_req_q && upd_ack_i) begin
      upd_req_n  = 1'b0;
      upd_done_n = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_done_q  <= 1'b0;
      rd_addr_q  <= '0;
      rd_data_q  <= '0;
      wr_done_q  <= 1'b0;
      wr_addr_q  <= '0;
      wr_data_q  <= '0;
      upd_req_q  <= 1'b0;
      upd_done_q <= 1'b0;
    end else begin
      rd_done_q  <= rd_done_n;
      rd_addr_q  <= rd_addr_n;
      rd_data_q  <= rd_data_n;
      wr_done_q  <= wr_done_n;
      wr_addr_q  <= wr_addr_n;
      wr_data_q  <= wr_data_n;
      upd_req_q  <= upd_req_n;
      upd_done_q <= upd_done_n;
    end
  end

  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_addr_i)
      OFF_RD: begin
        reg_rdata_o[BIT_DONE]            = rd_done_q;
        reg_rdata_o[BIT_ADDR +: ADDR_W]  = rd_addr_q;
        reg_rdata_o[BIT_DATA +: 16]      = rd_data_q;
      end
      OFF_WR: begin
        reg_rdata_o[BIT_DONE]            = wr_done_q;
        reg_rdata_o[BIT_ADDR +: ADDR_W]  = wr_addr_q;
        reg_rdata_o[BIT_DATA +: 16]      = wr_data_q;
      end
      OFF_CTL: begin
        reg_rdata_o[BIT_UPD_REQ]  = upd_req_q;
        reg_rdata_o[BIT_UPD_DONE] = upd_done_q;
        reg_rdata_o[BIT_BUSY]     = busy_i;
      end
      default: ;
    endcase
  end

  assign upd_req_o = upd_req_q;

  // R6: a command while busy leaves the latched addresses alone
  a_r6_busy_rd_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && reg_wr_i && reg_addr_i == OFF_RD) |=> $stable(rd_addr_q));
  a_r6_busy_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_i && reg_wr_i && reg_addr_i == OFF_WR) |=> $stable(wr_addr_q) && $stable(wr_data_q));
  // R5: acceptance drops done on the following cycle
  a_r5_go_clears_done: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_go_o || wr_go_o) |=> !(rd_done_q && $past(rd_go_o)) && !(wr_done_q && $past(wr_go_o)));
  // R8: acknowledge completes a pending commit
  a_r8_ack_completes: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_req_q && upd_ack_i) |=> upd_done_q && !upd_req_q);
endmodule

// File: rtl/eeword_engine.sv
`timescale 1ns/1ps
module eeword_engine
  import eew_pkg::*;
#(
  parameter int ADDR_W   = 14,
  parameter int HALF_DIV = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_wr,
  input  logic [1:0]  reg_addr,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata,
  output logic        upd_req,
  input  logic        upd_ack,
  output logic        spi_sclk,
  output logic        spi_cs_n,
  output logic        spi_mosi,
  input  logic        spi_miso
);
  logic [1:0]         rst_sync_q;
  logic               rst_int_n;
  logic               busy, rd_fin, wr_fin, rd_go, wr_go;
  logic [15:0]        rd_word, cmd_data;
  logic [ADDR_W-1:0]  cmd_addr;
  logic               x_start, x_done;
  logic [5:0]         x_len;
  logic [FRAME_W-1:0] x_tx;
  logic [RX_W-1:0]    x_rx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  eew_regs #(.ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_int_n),
    .reg_wr_i(reg_wr), .reg_addr_i(reg_addr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata),
    .busy_i(busy), .rd_fin_i(rd_fin), .wr_fin_i(wr_fin), .rd_word_i(rd_word),
    .rd_go_o(rd_go), .wr_go_o(wr_go), .cmd_addr_o(cmd_addr), .cmd_data_o(cmd_data),
    .upd_req_o(upd_req), .upd_ack_i(upd_ack)
  );

  eew_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk(clk), .rst_n(rst_int_n),
    .rd_go_i(rd_go), .wr_go_i(wr_go), .addr_i(cmd_addr), .data_i(cmd_data),
    .busy_o(busy), .rd_fin_o(rd_fin), .wr_fin_o(wr_fin), .rd_word_o(rd_word),
    .xfer_start_o(x_start), .xfer_len_o(x_len), .xfer_tx_o(x_tx),
    .xfer_done_i(x_done), .xfer_rx_i(x_rx)
  );

  eew_spi_shifter #(.HALF_DIV(HALF_DIV), .FRAME_W(FRAME_W), .RX_W(RX_W)) u_spi (
    .clk(clk), .rst_n(rst_int_n),
    .start_i(x_start), .len_i(x_len), .tx_i(x_tx),
    .done_o(x_done), .rx_o(x_rx),
    .sclk_o(spi_sclk), .cs_n_o(spi_cs_n), .mosi_o(spi_mosi), .miso_i(spi_miso)
  );
endmodule

// File: tb/eeword_engine_test.sv
`timescale 1ns/1ps
module eeword_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        upd_req;
  logic        upd_ack = 1'b0;
  logic        spi_sclk, spi_cs_n, spi_mosi;
  logic        spi_miso = 1'b0;

  int n_chk = 0;
  int n_fail = 0;
  int sclk_err = 0;

  // EEPROM model state
  logic [7:0]  mem [256];
  logic        wel = 1'b0;
  int          wip_cnt = 0;
  int          polls = 0;
  logic [15:0] last_rd_addr = 16'h0;
  logic [15:0] last_pg_addr = 16'h0;

  always #2 clk = ~clk;

  eeword_engine uut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .upd_req(upd_req), .upd_ack(upd_ack),
    .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi), .spi_miso(spi_miso)
  );

  // Serial EEPROM model, mode 0
  initial begin
    int bitc;
    logic [7:0]  op;
    logic [15:0] a16, dat, osh;
    for (int i = 0; i < 256; i++) mem[i] = 8'(i) ^ 8'h5A;
    forever begin
      @(negedge spi_cs_n);
      bitc = 0; op = 0; a16 = 0; dat = 0; osh = 0;
      forever begin
        @(posedge spi_sclk or posedge spi_cs_n);
        if (spi_cs_n) break;
        bitc++;
        if (bitc <= 8) op = {op[6:0], spi_mosi};
        else if (bitc <= 24) a16 = {a16[14:0], spi_mosi};
        else if (bitc <= 40) dat = {dat[14:0], spi_mosi};
        #1;
        if (op == 8'h03 && bitc == 24) begin
          osh = {mem[a16[7:0]], mem[a16[7:0] + 8'd1]};
          spi_miso = osh[15];
        end else if (op == 8'h05 && bitc == 8) begin
          osh = {7'b0, (wip_cnt != 0), 8'h00};
          spi_miso = osh[15];
        end else if ((op == 8'h03 && bitc > 24) || (op == 8'h05 && bitc > 8)) begin
          osh = {osh[14:0], 1'b0};
          spi_miso = osh[15];
        end
      end
      spi_miso = 1'b0;
      case (op)
        8'h06: if (bitc == 8) wel = 1'b1;
        8'h03: last_rd_addr = a16;
        8'h02: if (bitc == 40 && wel) begin
          mem[a16[7:0]]        = dat[15:8];
          mem[a16[7:0] + 8'd1] = dat[7:0];
          wel = 1'b0;
          wip_cnt = 3;
          polls = 0;
          last_pg_addr = a16;
        end
        8'h05: begin
          polls++;
          if (wip_cnt > 0) wip_cnt--;
        end
        default: ;
      endcase
    end
  end

  always @(negedge clk) if (spi_cs_n && spi_sclk) sclk_err++;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = 32'h0;
  endtask

  task automatic rd_reg(input logic [1:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic wait_done(input logic [1:0] a, input string req, output logic [31:0] v);
    bit ok = 0;
    for (int i = 0; i < 5000; i++) begin
      rd_reg(a, v);
      if (v[1]) begin ok = 1; break; end
    end
    if (!ok) chk(req, 32'h0, 32'h2);
  endtask

  function automatic logic [31:0] fmt(input logic [15:0] d, input logic [13:0] wa);
    return {d, wa, 1'b1, 1'b0};
  endfunction

  typedef struct packed {
    logic        wr;
    logic [13:0] wa;
    logic [15:0] dat;
  } vec_t;

  localparam vec_t VECS [7] = '{
    '{1'b0, 14'h003, 16'h5D5C},
    '{1'b1, 14'h003, 16'hBEEF},
    '{1'b0, 14'h003, 16'hBEEF},
    '{1'b0, 14'h010, 16'h7B7A},
    '{1'b1, 14'h07F, 16'h0001},
    '{1'b0, 14'h07F, 16'h0001},
    '{1'b0, 14'h004, 16'h5352}
  };

  task automatic run_all();
    logic [31:0] v;
    // R1: reset state
    rd_reg(2'd0, v); chk("R1 rd reg reset", v, 32'h0);
    rd_reg(2'd1, v); chk("R1 wr reg reset", v, 32'h0);
    rd_reg(2'd2, v); chk("R1 ctl reset", v, 32'h0);
    rd_reg(2'd3, v); chk("R1 offset 3", v, 32'h0);
    chk("R1 cs_n idle", {31'h0, spi_cs_n}, 32'h1);
    chk("R1 upd_req idle", {31'h0, upd_req}, 32'h0);

    // Vector walk: R2 reads, R3 programs, R5 done clear
    foreach (VECS[k]) begin
      logic [1:0] off = VECS[k].wr ? 2'd1 : 2'd0;
      wr_reg(off, {VECS[k].wr ? VECS[k].dat : 16'h0, VECS[k].wa, 1'b0, 1'b1});
      rd_reg(off, v);
      chk("R5 done cleared on accept", {31'h0, v[1]}, 32'h0);
      wait_done(off, VECS[k].wr ? "R3" : "R2", v);
      chk(VECS[k].wr ? "R3 wr reg" : "R2 rd reg", v, fmt(VECS[k].dat, VECS[k].wa));
      if (VECS[k].wr) begin
        chk("R3 low byte at even addr", {24'h0, mem[{VECS[k].wa[6:0], 1'b0}]}, {24'h0, VECS[k].dat[7:0]});
        chk("R3 high byte at odd addr", {24'h0, mem[{VECS[k].wa[6:0], 1'b1}]}, {24'h0, VECS[k].dat[15:8]});
        chk("R3 program byte addr", {16'h0, last_pg_addr}, {17'h0, VECS[k].wa, 1'b0});
        chk("R4 status polls", polls, 4);
      end else begin
        chk("R2 read byte addr", {16'h0, last_rd_addr}, {17'h0, VECS[k].wa, 1'b0});
      end
    end

    // R4: not done while the device still reports busy
    wr_reg(2'd1, {16'h1357, 14'h008, 2'b01});
    for (int i = 0; i < 5000 && polls < 3; i++) @(negedge clk);
    rd_reg(2'd1, v);
    chk("R4 done held while write in progress", {31'h0, v[1]}, 32'h0);
    wait_done(2'd1, "R4", v);
    chk("R4 done after idle status", v, fmt(16'h1357, 14'h008));
    chk("R4 poll count", polls, 4);

    // R6: busy flag and ignored command
    wr_reg(2'd0, {16'h0, 14'h003, 2'b01});
    rd_reg(2'd2, v);
    chk("R6 busy flag", v, 32'h8000_0000);
    wr_reg(2'd1, {16'hAAAA, 14'h020, 2'b01});
    wait_done(2'd0, "R6", v);
    chk("R6 read still completes", v, fmt(16'hBEEF, 14'h003));
    repeat (600) @(negedge clk);
    rd_reg(2'd1, v);
    chk("R6 wr reg untouched", v, fmt(16'h1357, 14'h008));
    chk("R6 eeprom untouched", {24'h0, mem[8'h40]}, 32'h1A);
    rd_reg(2'd2, v);
    chk("R6 busy cleared", v, 32'h0);

    // R5: done and data persist
    repeat (50) @(negedge clk);
    rd_reg(2'd0, v);
    chk("R5 done and data persist", v, fmt(16'hBEEF, 14'h003));

    // R7: go bit clear does nothing
    wr_reg(2'd0, {16'h0, 14'h005, 2'b00});
    repeat (5) @(negedge clk);
    rd_reg(2'd2, v);
    chk("R7 no start", v, 32'h0);
    rd_reg(2'd0, v);
    chk("R7 rd reg unchanged", v, fmt(16'hBEEF, 14'h003));

    // R8: commit handshake
    wr_reg(2'd2, 32'h0080_0000);
    rd_reg(2'd2, v);
    chk("R8 request raised", v, 32'h0080_0000);
    repeat (10) @(negedge clk);
    chk("R8 upd_req held", {31'h0, upd_req}, 32'h1);
    @(negedge clk); upd_ack = 1'b1;
    @(negedge clk); upd_ack = 1'b0;
    rd_reg(2'd2, v);
    chk("R8 commit done", v, 32'h0400_0000);
    chk("R8 upd_req dropped", {31'h0, upd_req}, 32'h0);
    wr_reg(2'd2, 32'h0);
    rd_reg(2'd2, v);
    chk("R8 zero write no effect", v, 32'h0400_0000);
    wr_reg(2'd2, 32'h0080_0000);
    rd_reg(2'd2, v);
    chk("R8 new request clears done", v, 32'h0080_0000);

    // R9: mode 0 idle clock
    chk("R9 sclk low while deselected", sclk_err, 0);
  endtask

  initial begin
    bit timed_out = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    fork
      run_all();
      begin
        repeat (200000) @(posedge clk);
        timed_out = 1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end
endmodule